// File: doc/BRIEF.md
# Compare-Value System Timer Channel

This block is one timer channel that watches an external free-running 64-bit count and raises a level interrupt once that count has reached a programmed target. Software sets the target in one of two ways. It can write the target as an absolute 64-bit value. It can also write a signed 32-bit distance from the present count. Either way the same compare register is updated, and reading back through the relative view shows how many ticks remain. The value goes negative once the deadline has passed.

A control register holds an enable bit and an interrupt-mask bit. A read-only status bit reports the timer condition whenever the channel is enabled, even while the mask keeps the interrupt line low. Software therefore has two ways to quiet the line: set the mask or clear the enable. Registers are reached through a simple synchronous port. A write lands on the clock edge where the strobe is high. Reads are combinational from the address.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, the enable and mask bits are 0, the compare value is 0, and irqOut is low.
- R2: In the control register (address 0), bit 0 is enable and bit 1 is mask. Both are written from busWdata and read back on busRdata from the cycle after the write strobe.
- R3: Control bit 2 is the read-only status bit. Writes to bit 2 and to bits 63..3 have no effect, and bits 63..3 always read as zero.
- R4: The status bit is 1 exactly when enable is 1 and the count is greater than or equal to the compare value. The comparison is unsigned, so a compare value below the count is met at once.
- R5: The status bit reports the condition whether or not the mask bit is set. With the mask set, irqOut stays low.
- R6: irqOut is high exactly when the status condition holds and the mask bit is clear. It stays high for as long as that is so.
- R7: With enable cleared, irqOut is low and the status bit reads 0, whatever the compare value.
- R8: A write to address 2 sets the compare value to the count at the write edge plus the sign-extended low 32 bits of busWdata.
- R9: A read of address 2 returns the low 32 bits of (compare value minus count), sign-extended to 64 bits.
- R10: A write to address 1 loads all 64 bits of busWdata as the compare value, and a read of address 1 returns it.
- R11: The comparison spans all 64 bits. The condition is not met while the count is below the compare value, even when only the upper 32 bits differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| counterIn | input | 64 | Free-running system count |
| busWrite | input | 1 | Write strobe for the register at busAddr |
| busAddr | input | 2 | Register select: 0 control, 1 compare, 2 relative value |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Level interrupt |

## Verification
The checker tests on every cycle that irqOut never rises while the channel is masked or disabled, or while the count is below the target. It also tests that the control read-back keeps its upper bits at zero and that its status bit agrees with the unsigned compare. For each write it confirms that the compare register takes the absolute value or the count-relative sum on the next cycle. The directed scenarios are needed for the rest. These are the reset values, the exact count at which the condition flips, the sign change of the relative read-back once the deadline passes, and comparisons where only the upper 32 bits decide the result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DEF_CNT_W = 64;
  localparam int DEF_TV_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TVAL = 2'd2;

  localparam int ENA_BIT = 0;
  localparam int MASK_BIT = 1;
  localparam int STAT_BIT = 2;

  typedef struct packed {
    logic wrCtrl;
    logic wrCmp;
    logic wrTval;
    logic rdCtrl;
    logic rdCmp;
    logic rdTval;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    unique case (busAddr)
      ADDR_CTRL: begin stb.rdCtrl = 1'b1; stb.wrCtrl = busWrite; end
      ADDR_CMP:  begin stb.rdCmp  = 1'b1; stb.wrCmp  = busWrite; end
      ADDR_TVAL: begin stb.rdTval = 1'b1; stb.wrTval = busWrite; end
      default:   stb = '0;
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int TV_W = DEF_TV_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] counter,
  output logic [CNT_W-1:0] rdata,
  output logic             enableQ,
  output logic             maskQ,
  output logic [CNT_W-1:0] cmpQ,
  output logic             irq
);
  localparam int EXT_W = CNT_W - TV_W;

  logic [CNT_W-1:0] relWr;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] relRd;
  logic [CNT_W-1:0] ctrlRd;
  logic             condMet;

  generate
    if (EXT_W > 0) begin : g_ext
      assign relWr = {{EXT_W{wdata[TV_W-1]}}, wdata[TV_W-1:0]};
      assign relRd = {{EXT_W{remain[TV_W-1]}}, remain[TV_W-1:0]};
    end else begin : g_noext
      assign relWr = wdata;
      assign relRd = remain;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      maskQ <= 1'b0;
      cmpQ <= '0;
    end else begin
      if (stb.wrCtrl) begin
        enableQ <= wdata[ENA_BIT];
        maskQ <= wdata[MASK_BIT];
      end
      if (stb.wrCmp) cmpQ <= wdata;
      else if (stb.wrTval) cmpQ <= counter + relWr;
    end
  end

  assign remain = cmpQ - counter;
  assign condMet = enableQ && (counter >= cmpQ);
  assign irq = condMet && !maskQ;

  always_comb begin
    ctrlRd = '0;
    ctrlRd[ENA_BIT] = enableQ;
    ctrlRd[MASK_BIT] = maskQ;
    ctrlRd[STAT_BIT] = condMet;
  end

  always_comb begin
    rdata = '0;
    if (stb.rdCtrl) rdata = ctrlRd;
    else if (stb.rdCmp) rdata = cmpQ;
    else if (stb.rdTval) rdata = relRd;
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int TV_W = DEF_TV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  counterIn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);
  strobe_t          stb;
  logic             enableQ;
  logic             maskQ;
  logic [CNT_W-1:0] cmpQ;

  tmr_ctrl u_ctrl (
    .busWrite(busWrite),
    .busAddr(busAddr),
    .stb(stb)
  );

  tmr_datapath #(.CNT_W(CNT_W), .TV_W(TV_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wdata(busWdata),
    .counter(counterIn),
    .rdata(busRdata),
    .enableQ(enableQ),
    .maskQ(maskQ),
    .cmpQ(cmpQ),
    .irq(irqOut)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int TV_W = DEF_TV_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  counterIn,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic [CNT_W-1:0]  busRdata,
  input logic              irqOut,
  input logic              enableQ,
  input logic              maskQ,
  input logic [CNT_W-1:0]  cmpQ
);
  logic [CNT_W-1:0] wSext;
  assign wSext = {{(CNT_W-TV_W){busWdata[TV_W-1]}}, busWdata[TV_W-1:0]};

  // R3
  upper_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdata[CNT_W-1:3] == '0));

  // R4
  status_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdata[STAT_BIT] == (busRdata[ENA_BIT] && (counterIn >= cmpQ))));

  // R5
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irqOut);

  // R6
  irq_only_when_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (counterIn >= cmpQ));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> !irqOut);

  // R8
  rel_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_TVAL) |=> (cmpQ == $past(counterIn + wSext)));

  // R10
  abs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_CMP) |=> (cmpQ == $past(busWdata)));
endmodule

bind cmp_timer_chan tmr_chk #(.CNT_W(CNT_W), .TV_W(TV_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .counterIn(counterIn),
  .busWrite(busWrite),
  .busAddr(busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqOut(irqOut),
  .enableQ(enableQ),
  .maskQ(maskQ),
  .cmpQ(cmpQ)
);

// File: tb/cmp_timer_chan_test.sv
module cmp_timer_chan_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] counterIn = '0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer_chan uut (
    .clk(clk), .rstN(rstN), .counterIn(counterIn),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [63:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic setCount(logic [63:0] v);
    @(negedge clk);
    counterIn = v;
    #1;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 64'h0);
    rd(2'd1, d); check("R1 cmp", d, 64'h0);
    check("R1 irq", {63'h0, irqOut}, 64'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [63:0] d;
    setCount(64'd5);
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFF8);
    rd(2'd0, d); check("R3 ignored bits", d, 64'h0);
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, d); check("R2 R3 ctrl readback", d, 64'h7);
    check("R5 masked irq", {63'h0, irqOut}, 64'h0);
    wr(2'd0, 64'h0);
  endtask

  task automatic t_compare();
    logic [63:0] d;
    setCount(64'd100);
    wr(2'd1, 64'd200);
    wr(2'd0, 64'h1);
    rd(2'd0, d); check("R4 below target", d, 64'h1);
    check("R6 irq low below", {63'h0, irqOut}, 64'h0);
    setCount(64'd199);
    rd(2'd0, d); check("R4 one below", d, 64'h1);
    setCount(64'd200);
    rd(2'd0, d); check("R4 at target", d, 64'h5);
    check("R6 irq at target", {63'h0, irqOut}, 64'h1);
    setCount(64'd300);
    check("R6 irq held", {63'h0, irqOut}, 64'h1);
  endtask

  task automatic t_mask_disable();
    logic [63:0] d;
    wr(2'd0, 64'h3);
    rd(2'd0, d); check("R5 status while masked", d, 64'h7);
    check("R5 irq masked", {63'h0, irqOut}, 64'h0);
    wr(2'd0, 64'h0);
    rd(2'd0, d); check("R7 disabled status", d, 64'h0);
    check("R7 disabled irq", {63'h0, irqOut}, 64'h0);
    wr(2'd1, 64'h0);
    check("R7 zero cmp disabled", {63'h0, irqOut}, 64'h0);
    wr(2'd0, 64'h1);
    check("R4 zero cmp met", {63'h0, irqOut}, 64'h1);
    wr(2'd0, 64'h0);
  endtask

  task automatic t_relative();
    logic [63:0] d;
    setCount(64'd1000);
    wr(2'd2, 64'hAAAA_5555_0000_0032);
    rd(2'd1, d); check("R8 positive rel", d, 64'd1050);
    setCount(64'd1010);
    rd(2'd2, d); check("R9 remaining", d, 64'd40);
    setCount(64'd1060);
    rd(2'd2, d); check("R9 expired negative", d, 64'hFFFF_FFFF_FFFF_FFF6);
    setCount(64'd1000);
    wr(2'd2, 64'h0000_0000_FFFF_FFFB);
    rd(2'd1, d); check("R8 negative rel", d, 64'd995);
    wr(2'd0, 64'h1);
    check("R4 past target at once", {63'h0, irqOut}, 64'h1);
    wr(2'd0, 64'h0);
  endtask

  task automatic t_wide();
    logic [63:0] d;
    wr(2'd1, 64'hDEAD_BEEF_0123_4567);
    rd(2'd1, d); check("R10 abs readback", d, 64'hDEAD_BEEF_0123_4567);
    wr(2'd1, 64'h1_0000_0000);
    wr(2'd0, 64'h1);
    setCount(64'h0_FFFF_FFFF);
    rd(2'd0, d); check("R11 upper half decides", d, 64'h1);
    setCount(64'h1_0000_0000);
    rd(2'd0, d); check("R11 reached", d, 64'h5);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    setCount(64'h8000_0000_0000_0000);
    rd(2'd0, d); check("R11 unsigned", d, 64'h1);
    check("R11 irq low", {63'h0, irqOut}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_compare();
    t_mask_disable();
    t_relative();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule